// File: doc/BRIEF.md
# Framed Serial Codec Data Port

This block is the device end of a synchronous serial link between a codec and its host. It is clocked by the serial bit clock and divides it into frames of a fixed length. Every frame opens with a primary slot. In that slot the block shifts a converter sample out on the data output and shifts a host sample in from the data input. A second slot, partway through the frame, is opened only when the host asks for it. That slot returns a register readback word and takes in a control word from the host.

The host asks for the second slot with the lowest bit of its primary word. The control word it sends there is decoded into a one-cycle register write strobe or read strobe, together with the address. The answer to a command goes out in the next secondary slot that runs. A tag mode replaces the lowest sample bit with the device's master/slave identity. The secondary output word always carries that identity in its top bit.

Top module: `codec_serial_port`

## Requirements
- R1: After reset the frame counter is 0. `fs_o` is high for the 16 cycles at counter values 0 to 15 of every 256-cycle frame.
- R2: In the primary slot `dout_o` sends a 16-bit word MSB first, one bit per cycle, changing only after rising edges. The word is `sample_i` as seen at the rising edge just before the slot.
- R3: When `tag_mode_i` is 1 at that load edge, bit 0 of the primary output word is `ms_i` (1 = master, 0 = slave) and bits 15..1 are `sample_i[15:1]`.
- R4: A secondary slot (`fs_o` high at counter values 128 to 143) runs in a frame only when bit 0 of that frame's primary input word was 1.
- R5: The secondary output word is loaded at the rising edge just before the slot. Its bits are: bit 15 `ms_i`, bit 14 zero, bit 13 read flag, bits 12..8 address, bits 7..0 data. The flag, address and data belong to the last completed command. The data is the readback value for a read and zero for a write. All three are zero after reset.
- R6: `din_i` is sampled on falling edges while the primary slot is active. In the cycle after the 16th bit, `rx_valid_o` pulses for one cycle and `rx_data_o` presents the word, MSB first received. `rx_data_o` holds the word afterwards.
- R7: In the cycle after the 16th bit of a secondary slot, the received word is decoded. If bit 13 is 1, `reg_rd_o` pulses with `reg_addr_o` = bits 12..8, and `reg_rdata_i` is sampled in that same cycle. If bit 13 is 0, `reg_we_o` pulses with `reg_addr_o` = bits 12..8 and `reg_wdata_o` = bits 7..0. The two strobes are never high together.
- R8: `dout_o` is low whenever `fs_o` is low. `din_i` values outside an active slot produce no strobe. This includes the secondary position in a frame where that slot is not requested.
- R9: During reset `dout_o`, `rx_valid_o`, `reg_we_o` and `reg_rd_o` are low. The first primary slot after reset sends an all-zero word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tag_mode_i | input | 1 | 1 = 15-bit sample plus identity bit, 0 = plain 16-bit |
| ms_i | input | 1 | Device identity, 1 = master, 0 = slave |
| sample_i | input | 16 | Converter sample to transmit |
| din_i | input | 1 | Serial data from host |
| fs_o | output | 1 | Frame sync, high during an active slot |
| dout_o | output | 1 | Serial data to host |
| rx_valid_o | output | 1 | One-cycle strobe for a received primary word |
| rx_data_o | output | 16 | Received primary word |
| reg_we_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_addr_o | output | 5 | Register address of the last command |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data, sampled while `reg_rd_o` is high |

## Verification
On one rising edge, the primary receive completes: the valid strobe rises and the secondary-request bit is latched. The secondary slot that this bit opens or suppresses falls 112 cycles later in the same frame. The bench sets the request bit at random in every frame and sends a full control word at the secondary position either way. It then judges `fs_o`, `dout_o` and both register strobes against its own frame model.

A read strobe and the capture of read data share one cycle. The readback then has to appear in a later secondary slot, even when frames without a secondary slot come in between. Directed frames cover this case: write, then read, then a frame with no secondary slot, then a write.

// File: rtl/csp_pkg.sv
package csp_pkg;
  parameter int unsigned WORD_W    = 16;
  parameter int unsigned FRAME_LEN = 256;
  parameter int unsigned SEC_OFF   = 128;
  parameter int unsigned ADDR_W    = 5;
  parameter int unsigned DATA_W    = 8;
  localparam int unsigned RD_POS   = DATA_W + ADDR_W;
  localparam int unsigned SPARE_W  = WORD_W - 2 - ADDR_W - DATA_W;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.rd   = w[RD_POS];
    c.addr = w[RD_POS-1:DATA_W];
    c.data = w[DATA_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/csp_frame_timer.sv
module csp_frame_timer #(
  parameter int unsigned FRAME_LEN = 256,
  parameter int unsigned SEC_OFF   = 128,
  parameter int unsigned SLOT_LEN  = 16,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             prim_slot_o,
  output logic             sec_slot_o,
  output logic             load_prim_o,
  output logic             load_sec_o,
  output logic             prim_last_o,
  output logic             sec_last_o
);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] P_LAST    = CNT_W'(SLOT_LEN - 1);
  localparam logic [CNT_W-1:0] P_END     = CNT_W'(SLOT_LEN);
  localparam logic [CNT_W-1:0] S_FIRST   = CNT_W'(SEC_OFF);
  localparam logic [CNT_W-1:0] S_PRE     = CNT_W'(SEC_OFF - 1);
  localparam logic [CNT_W-1:0] S_LAST    = CNT_W'(SEC_OFF + SLOT_LEN - 1);
  localparam logic [CNT_W-1:0] S_END     = CNT_W'(SEC_OFF + SLOT_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (cnt_q == CNT_LAST) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o       = cnt_q;
  assign prim_slot_o = cnt_q < P_END;
  assign sec_slot_o  = sec_en_i && (cnt_q >= S_FIRST) && (cnt_q < S_END);
  assign load_prim_o = cnt_q == CNT_LAST;
  assign load_sec_o  = sec_en_i && (cnt_q == S_PRE);
  assign prim_last_o = cnt_q == P_LAST;
  assign sec_last_o  = sec_en_i && (cnt_q == S_LAST);

  // R1: frame wraps to zero
  p_frame_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_LAST) |=> (cnt_q == '0));
  // R4: slots never overlap
  p_slot_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(prim_slot_o && sec_slot_o));
endmodule

// File: rtl/csp_tx_shifter.sv
module csp_tx_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         shift_i,
  input  logic         active_i,
  output logic         dout_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign dout_o = active_i & sh_q[W-1];

  // R2: the first slot bit is the MSB of the loaded word
  p_msb_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(load_i) && active_i) |-> (dout_o == $past(word_i[W-1])));
endmodule

// File: rtl/csp_rx_shifter.sv
module csp_rx_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         din_i,
  input  logic         shift_i,
  output logic [W-1:0] word_o
);
  logic         din_q;
  logic [W-1:0] sh_q;

  // host data is taken on the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) din_q <= 1'b0;
    else         din_q <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (shift_i) sh_q <= word_o;
  end

  assign word_o = {sh_q[W-2:0], din_q};
endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
  import csp_pkg::*;
#(
  parameter int unsigned FRAME_LEN = csp_pkg::FRAME_LEN,
  parameter int unsigned SEC_OFF   = csp_pkg::SEC_OFF,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tag_mode_i,
  input  logic              ms_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic              din_i,
  output logic              fs_o,
  output logic              dout_o,
  output logic              rx_valid_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              reg_we_o,
  output logic              reg_rd_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic [CNT_W-1:0]  cnt;
  logic              prim_slot, sec_slot, load_prim, load_sec, prim_last, sec_last;
  logic              sec_en_q;
  logic [WORD_W-1:0] rx_word, prim_word, sec_word, tx_word;
  cmd_t              sec_cmd;

  logic              rx_valid_q, we_q, rd_q;
  logic [WORD_W-1:0] rx_data_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              resp_rd_q;
  logic [ADDR_W-1:0] resp_addr_q;
  logic [DATA_W-1:0] resp_data_q;

  csp_frame_timer #(
    .FRAME_LEN(FRAME_LEN),
    .SEC_OFF  (SEC_OFF),
    .SLOT_LEN (WORD_W)
  ) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sec_en_i   (sec_en_q),
    .cnt_o      (cnt),
    .prim_slot_o(prim_slot),
    .sec_slot_o (sec_slot),
    .load_prim_o(load_prim),
    .load_sec_o (load_sec),
    .prim_last_o(prim_last),
    .sec_last_o (sec_last)
  );

  assign prim_word = tag_mode_i ? {sample_i[WORD_W-1:1], ms_i} : sample_i;
  assign sec_word  = {ms_i, {SPARE_W{1'b0}}, resp_rd_q, resp_addr_q, resp_data_q};
  assign tx_word   = load_prim ? prim_word : sec_word;
  assign fs_o      = prim_slot | sec_slot;

  csp_tx_shifter #(.W(WORD_W)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_prim | load_sec),
    .word_i  (tx_word),
    .shift_i (fs_o),
    .active_i(fs_o),
    .dout_o  (dout_o)
  );

  csp_rx_shifter #(.W(WORD_W)) i_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  (din_i),
    .shift_i(fs_o),
    .word_o (rx_word)
  );

  assign sec_cmd = decode_cmd(rx_word);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_en_q    <= 1'b0;
      rx_valid_q  <= 1'b0;
      rx_data_q   <= '0;
      we_q        <= 1'b0;
      rd_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      resp_rd_q   <= 1'b0;
      resp_addr_q <= '0;
      resp_data_q <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      we_q       <= 1'b0;
      rd_q       <= 1'b0;
      if (prim_last) begin
        rx_valid_q <= 1'b1;
        rx_data_q  <= rx_word;
        sec_en_q   <= rx_word[0];
      end
      if (sec_last) begin
        we_q        <= !sec_cmd.rd;
        rd_q        <= sec_cmd.rd;
        addr_q      <= sec_cmd.addr;
        resp_rd_q   <= sec_cmd.rd;
        resp_addr_q <= sec_cmd.addr;
        if (!sec_cmd.rd) begin
          wdata_q     <= sec_cmd.data;
          resp_data_q <= '0;
        end
      end
      if (rd_q) resp_data_q <= reg_rdata_i;
    end
  end

  assign rx_valid_o  = rx_valid_q;
  assign rx_data_o   = rx_data_q;
  assign reg_we_o    = we_q;
  assign reg_rd_o    = rd_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;

  // R6: receive strobe is a single-cycle pulse
  p_rx_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R7: read and write strobes exclusive
  p_strobe_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_rd_o}));
  // R7: strobes only right after a secondary slot closes
  p_strobe_after_sec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || reg_rd_o) |-> ($past(sec_slot) && !sec_slot));
  // R8: data line quiet outside slots
  p_dout_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_o |-> !dout_o);
endmodule

// File: tb/test_codec_serial_port.sv
module test_codec_serial_port;
  localparam int NF = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tag_mode, ms, din;
  logic [15:0] sample;
  logic [7:0]  rdata;
  logic        fs, dout, rx_valid, reg_we, reg_rd;
  logic [15:0] rx_data;
  logic [4:0]  reg_addr;
  logic [7:0]  reg_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  codec_serial_port i_codec_serial_port (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .tag_mode_i (tag_mode),
    .ms_i       (ms),
    .sample_i   (sample),
    .din_i      (din),
    .fs_o       (fs),
    .dout_o     (dout),
    .rx_valid_o (rx_valid),
    .rx_data_o  (rx_data),
    .reg_we_o   (reg_we),
    .reg_rd_o   (reg_rd),
    .reg_addr_o (reg_addr),
    .reg_wdata_o(reg_wdata),
    .reg_rdata_i(rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rd_model(input logic [4:0] a);
    return {a[2:0], a} ^ 8'hA5;
  endfunction

  initial begin
    logic [15:0] hw, cw, prim_w, sec_w;
    logic        sec_f, resp_rd, exp_fs, exp_do;
    logic [4:0]  resp_addr;
    logic [7:0]  resp_data;
    void'($urandom(32'd20240917));
    tag_mode = 1'b0; ms = 1'b0; din = 1'b0; sample = '0; rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(!dout && !rx_valid && !reg_we && !reg_rd, "R9 reset outputs",
        {dout, rx_valid, reg_we, reg_rd}, 0);
    @(posedge clk); #1 rst_ni = 1'b1;
    prim_w = '0; sec_w = '0; resp_rd = 1'b0; resp_addr = '0; resp_data = '0;
    hw = '0; cw = '0; sec_f = 1'b0;
    for (int f = 0; f < NF; f++) begin
      for (int p = 0; p < 256; p++) begin
        if (p == 0) begin
          hw = 16'($urandom);
          cw = 16'($urandom);
          case (f)
            0: begin hw[0] = 1'b1; cw = 16'h033C; end
            1: begin hw[0] = 1'b1; cw = 16'h3F55; end
            2: hw[0] = 1'b0;
            3: begin hw[0] = 1'b1; cw = 16'h0A81; end
            default: ;
          endcase
          sec_f = hw[0];
        end
        if (p == 16) begin
          sample = 16'($urandom);
          case (f)
            0: begin tag_mode = 1'b1; ms = 1'b1; end
            1: begin tag_mode = 1'b1; ms = 1'b0; end
            2: begin tag_mode = 1'b0; ms = 1'b1; end
            default: begin tag_mode = 1'($urandom); ms = 1'($urandom); end
          endcase
        end
        if (p < 16)                   din = hw[15-p];
        else if (p >= 128 && p < 144) din = cw[15-(p-128)];
        else                          din = 1'($urandom);
        rdata = (p == 144) ? rd_model(cw[12:8]) : 8'($urandom);

        @(negedge clk);
        exp_fs = (p < 16) || (sec_f && p >= 128 && p < 144);
        chk(fs == exp_fs, (p >= 128) ? "R4 secondary frame sync" : "R1 primary frame sync", fs, exp_fs);
        if (p < 16)                            exp_do = prim_w[15-p];
        else if (sec_f && p >= 128 && p < 144) exp_do = sec_w[15-(p-128)];
        else                                   exp_do = 1'b0;
        if (p < 16)
          chk(dout == exp_do, (f == 0) ? "R9 first word zero" : "R2/R3 primary bit", dout, exp_do);
        else if (exp_fs)
          chk(dout == exp_do, "R5 secondary bit", dout, exp_do);
        else
          chk(dout == 1'b0, "R8 dout low outside slot", dout, 0);
        chk(rx_valid == (p == 16), "R6 rx_valid pulse", rx_valid, (p == 16));
        if (p == 16) chk(rx_data == hw, "R6 rx_data", rx_data, hw);
        if (p == 144 && sec_f) begin
          chk(reg_rd == cw[13] && reg_we == !cw[13], "R7 strobe kind", {reg_we, reg_rd}, {!cw[13], cw[13]});
          chk(reg_addr == cw[12:8], "R7 address", reg_addr, cw[12:8]);
          if (!cw[13]) chk(reg_wdata == cw[7:0], "R7 write data", reg_wdata, cw[7:0]);
          resp_rd   = cw[13];
          resp_addr = cw[12:8];
          resp_data = cw[13] ? rd_model(cw[12:8]) : 8'h00;
        end else begin
          chk(!reg_rd && !reg_we, "R8 no strobe", {reg_we, reg_rd}, 0);
        end
        if (p == 127) sec_w = {ms, 1'b0, resp_rd, resp_addr, resp_data};
        if (p == 255) prim_w = tag_mode ? {sample[15:1], ms} : sample;
        @(posedge clk); #1;
      end
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule